// File: doc/BRIEF.md
# Sequenced Protection Response Register

This block is a small read-only peripheral on a 16-bit data bus. It lets host software confirm that an expected custom part is fitted. Two word locations return fixed identification words. Four other locations replay two eight-step byte sequences. Each step is held in a 16-bit constant and is handed out one byte per read. A single 3-bit position, shared by both sequences, selects the step.

The low pair of sequence locations returns the secondary sequence with the byte right-justified. The top pair of the offset space returns the primary sequence with the byte in the high lane. In each pair, the first location gives the upper byte of the current step and leaves the position alone. The second gives the lower byte and then moves the position one step forward.

An access is recognised on the first cycle the read strobe is high. The answer is registered and appears one clock later. The position moves on that same edge, so the returned byte always belongs to the step that was current before the advance.

Top module: `seqkey_resp`

## Requirements
- R1: A read of word offset 0 returns 0x0101 and a read of word offset 1 returns 0x3E55; neither read changes the position.
- R2: The position is a 3-bit value that wraps from 7 to 0. Primary steps 0..7 are 0x0000, 0x0040, 0x0440, 0x2440, 0x2480, 0xA080, 0x8081, 0x8041. Secondary steps 0..7 are 0x0040, 0x0060, 0x0060, 0x0860, 0x0864, 0x08E4, 0x08E5, 0x08A5.
- R3: A read of word offset 2 returns the upper byte of the current secondary step in bits 7:0, with bits 15:8 zero, and leaves the position unchanged.
- R4: A read of word offset 3 returns the lower byte of the current secondary step in bits 7:0, with bits 15:8 zero, and then advances the position by one.
- R5: A read of the second-highest word offset (all ones except bit 0) returns the upper byte of the current primary step in bits 15:8, with bits 7:0 zero, and leaves the position unchanged.
- R6: A read of the highest word offset (all ones) returns the lower byte of the current primary step in bits 15:8, with bits 7:0 zero, and then advances the position by one.
- R7: A read of any other offset returns 0x0000 and leaves the position unchanged.
- R8: An access is a cycle with rd_en high that follows a cycle with rd_en low. Further cycles with rd_en held high neither advance the position nor change rd_data, even if rd_offset changes.
- R9: rd_data takes the answer at the clock edge that ends the access cycle. It reflects the position from before any advance, and it holds its value until the next access.
- R10: A synchronous active-low reset clears the position and rd_data to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe; its rising level starts one access |
| rd_offset | input | OFFSET_W | Word offset of the access |
| rd_data | output | 16 | Registered read data |

## Verification
The capture of the answer and the advance of the position happen on the same clock edge. A read of an advancing location is therefore judged by the byte it returns, which must come from the old step, and by the upper byte returned by the next non-advancing read, which must come from the new step. Both sequences are read in one interleaved pass because they share the position. A strobe is held high across several cycles while the offset is switched, which provokes a possible second advance or recapture in the same access. The bench then reads back the unchanged rd_data and the single-step position.

// File: rtl/seqkey_pkg.sv
// Package seqkey_pkg
// Holds the shared access kinds and the two eight-step constant sequences.
// Assumes a 3-bit position; both sequences are indexed by the same value.
package seqkey_pkg;

    localparam int POS_W  = 3;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        KIND_ID_A   = 3'd0,
        KIND_ID_B   = 3'd1,
        KIND_SEC_HI = 3'd2,
        KIND_SEC_LO = 3'd3,
        KIND_PRI_HI = 3'd4,
        KIND_PRI_LO = 3'd5,
        KIND_NONE   = 3'd6
    } access_kind_t;

    localparam logic [DATA_W-1:0] ID_WORD_A = 16'h0101;
    localparam logic [DATA_W-1:0] ID_WORD_B = 16'h3E55;

    // Step value of the primary sequence at a position.
    function automatic logic [DATA_W-1:0] primary_step(input logic [POS_W-1:0] p);
        case (p)
            3'd0:    primary_step = 16'h0000;
            3'd1:    primary_step = 16'h0040;
            3'd2:    primary_step = 16'h0440;
            3'd3:    primary_step = 16'h2440;
            3'd4:    primary_step = 16'h2480;
            3'd5:    primary_step = 16'hA080;
            3'd6:    primary_step = 16'h8081;
            default: primary_step = 16'h8041;
        endcase
    endfunction

    // Step value of the secondary sequence at a position.
    function automatic logic [DATA_W-1:0] secondary_step(input logic [POS_W-1:0] p);
        case (p)
            3'd0:    secondary_step = 16'h0040;
            3'd1:    secondary_step = 16'h0060;
            3'd2:    secondary_step = 16'h0060;
            3'd3:    secondary_step = 16'h0860;
            3'd4:    secondary_step = 16'h0864;
            3'd5:    secondary_step = 16'h08E4;
            3'd6:    secondary_step = 16'h08E5;
            default: secondary_step = 16'h08A5;
        endcase
    endfunction

endpackage

// File: rtl/seqkey_decode.sv
// Module seqkey_decode
// Classifies a word offset into one access kind.
// Assumes OFFSET_W >= 3 so the two lowest pairs and the top pair never overlap.
module seqkey_decode
    import seqkey_pkg::*;
#(
    parameter int OFFSET_W = 17
) (
    input  logic [OFFSET_W-1:0] offset,
    output access_kind_t        kind
);
    localparam logic [OFFSET_W-1:0] TOP_OFF  = '1;
    localparam logic [OFFSET_W-1:0] NEXT_OFF = TOP_OFF - OFFSET_W'(1);

    // Map offset to kind; unlisted offsets fall to KIND_NONE.
    always_comb begin
        if (offset == OFFSET_W'(0))      kind = KIND_ID_A;
        else if (offset == OFFSET_W'(1)) kind = KIND_ID_B;
        else if (offset == OFFSET_W'(2)) kind = KIND_SEC_HI;
        else if (offset == OFFSET_W'(3)) kind = KIND_SEC_LO;
        else if (offset == NEXT_OFF)     kind = KIND_PRI_HI;
        else if (offset == TOP_OFF)      kind = KIND_PRI_LO;
        else                             kind = KIND_NONE;
    end
endmodule

// File: rtl/seqkey_strobe.sv
// Module seqkey_strobe
// Turns a level read strobe into a single-cycle access pulse.
// Assumes the strobe is synchronous to clk. The history flop follows the
// strobe even during reset, so a strobe held through reset does not count.
module seqkey_strobe (
    input  logic clk,
    input  logic strobe,
    output logic access
);
    logic prev_q;

    // Remember last cycle's strobe level.
    always_ff @(posedge clk) begin
        prev_q <= strobe;
    end

    // Access on the first high cycle only.
    always_comb begin
        access = strobe && !prev_q;
    end
endmodule

// File: rtl/seqkey_ptr.sv
// Module seqkey_ptr
// Shared position into both sequences; steps by one on request and wraps.
// Assumes step is already qualified to one cycle per access.
module seqkey_ptr
    import seqkey_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [POS_W-1:0] pos
);
    // Clear on reset, otherwise advance modulo the table depth.
    always_ff @(posedge clk) begin
        if (!rst_n)    pos <= '0;
        else if (step) pos <= pos + POS_W'(1);
    end
endmodule

// File: rtl/seqkey_lane.sv
// Module seqkey_lane
// Splits the current step of one sequence into two bus words, one per byte.
// PLACE_HIGH picks the lane: 1 puts each byte in bits 15:8, 0 in bits 7:0.
// USE_PRIMARY picks which constant sequence is read.
module seqkey_lane
    import seqkey_pkg::*;
#(
    parameter bit USE_PRIMARY = 1'b0,
    parameter bit PLACE_HIGH  = 1'b0
) (
    input  logic [POS_W-1:0]  pos,
    output logic [DATA_W-1:0] upper_word,
    output logic [DATA_W-1:0] lower_word
);
    logic [DATA_W-1:0] step_val;

    generate
        if (USE_PRIMARY) begin : g_pri
            // Fetch the primary step.
            always_comb step_val = primary_step(pos);
        end else begin : g_sec
            // Fetch the secondary step.
            always_comb step_val = secondary_step(pos);
        end

        if (PLACE_HIGH) begin : g_high
            // Both bytes go to the high lane.
            always_comb begin
                upper_word = {step_val[DATA_W-1:BYTE_W], {BYTE_W{1'b0}}};
                lower_word = {step_val[BYTE_W-1:0],      {BYTE_W{1'b0}}};
            end
        end else begin : g_low
            // Both bytes go to the low lane.
            always_comb begin
                upper_word = {{BYTE_W{1'b0}}, step_val[DATA_W-1:BYTE_W]};
                lower_word = {{BYTE_W{1'b0}}, step_val[BYTE_W-1:0]};
            end
        end
    endgenerate
endmodule

// File: rtl/seqkey_resp.sv
// Module seqkey_resp
// Sequenced response register: fixed identity words plus two byte-serial
// sequences sharing one position. Read data is registered one cycle after
// the access; the position advances on the same edge for the second byte
// of each pair. Assumes a synchronous single-master bus with no wait states.
module seqkey_resp
    import seqkey_pkg::*;
#(
    parameter int OFFSET_W = 17
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [OFFSET_W-1:0] rd_offset,
    output logic [DATA_W-1:0]   rd_data
);
    access_kind_t      kind;
    logic              access;
    logic              advance;
    logic [POS_W-1:0]  pos_q;
    logic [DATA_W-1:0] sec_hi_w, sec_lo_w, pri_hi_w, pri_lo_w;
    logic [DATA_W-1:0] answer;

    seqkey_decode #(.OFFSET_W(OFFSET_W)) dec_i (
        .offset (rd_offset),
        .kind   (kind)
    );

    seqkey_strobe stb_i (
        .clk    (clk),
        .strobe (rd_en),
        .access (access)
    );

    seqkey_ptr ptr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (advance),
        .pos   (pos_q)
    );

    seqkey_lane #(.USE_PRIMARY(1'b0), .PLACE_HIGH(1'b0)) sec_i (
        .pos        (pos_q),
        .upper_word (sec_hi_w),
        .lower_word (sec_lo_w)
    );

    seqkey_lane #(.USE_PRIMARY(1'b1), .PLACE_HIGH(1'b1)) pri_i (
        .pos        (pos_q),
        .upper_word (pri_hi_w),
        .lower_word (pri_lo_w)
    );

    // Only the lower-byte reads of a pair move the position.
    always_comb begin
        advance = access && ((kind == KIND_SEC_LO) || (kind == KIND_PRI_LO));
    end

    // Select the word this access returns.
    always_comb begin
        case (kind)
            KIND_ID_A:   answer = ID_WORD_A;
            KIND_ID_B:   answer = ID_WORD_B;
            KIND_SEC_HI: answer = sec_hi_w;
            KIND_SEC_LO: answer = sec_lo_w;
            KIND_PRI_HI: answer = pri_hi_w;
            KIND_PRI_LO: answer = pri_lo_w;
            default:     answer = '0;
        endcase
    end

    // Register the answer on an access; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (access) rd_data <= answer;
    end
endmodule

// File: rtl/seqkey_resp_chk.sv
// Module seqkey_resp_chk
// Property checker for seqkey_resp, bound to every instance below.
// Assumes it sees the top ports plus the internal position.
module seqkey_resp_chk
    import seqkey_pkg::*;
#(
    parameter int OFFSET_W = 17
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd_en,
    input logic [OFFSET_W-1:0] rd_offset,
    input logic [DATA_W-1:0]   rd_data,
    input logic [POS_W-1:0]    pos
);
    localparam logic [OFFSET_W-1:0] TOP_OFF  = '1;
    localparam logic [OFFSET_W-1:0] NEXT_OFF = TOP_OFF - OFFSET_W'(1);

    p_id_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !$past(rd_en) && rd_offset == OFFSET_W'(0)) |=> (rd_data == 16'h0101 && $stable(pos)));

    p_sec_hi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !$past(rd_en) && rd_offset == OFFSET_W'(2)) |=> ($stable(pos) && rd_data[15:8] == 8'h00));

    p_sec_lo_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !$past(rd_en) && rd_offset == OFFSET_W'(3)) |=> (pos == POS_W'($past(pos) + 3'd1)));

    p_pri_hi_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !$past(rd_en) && rd_offset == NEXT_OFF) |=> (rd_data[7:0] == 8'h00 && $stable(pos)));

    p_pri_lo_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !$past(rd_en) && rd_offset == TOP_OFF) |=> (pos == POS_W'($past(pos) + 3'd1)));

    p_held_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |=> ($stable(pos) && $stable(rd_data)));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ($stable(pos) && $stable(rd_data)));
endmodule

bind seqkey_resp seqkey_resp_chk #(.OFFSET_W(OFFSET_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_offset (rd_offset),
    .rd_data   (rd_data),
    .pos       (pos_q)
);

// File: tb/seqkey_resp_tb_top.sv
// Bench for seqkey_resp: sweeps every step of both sequences in several
// read orders, plus identity, unmapped, held-strobe and reset cases.
module seqkey_resp_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int OW = 17;
    localparam int TOP = (1 << OW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_en = 1'b0;
    logic [OW-1:0] rd_offset = '0;
    logic [15:0]   rd_data;

    int checks = 0;
    int failures = 0;
    int model_pos = 0;
    bit finished = 1'b0;

    seqkey_resp #(.OFFSET_W(OW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_offset (rd_offset),
        .rd_data   (rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Sequence values from R2.
    function automatic int pri_v(int p);
        int t [8] = '{16'h0000, 16'h0040, 16'h0440, 16'h2440, 16'h2480, 16'hA080, 16'h8081, 16'h8041};
        return t[p % 8];
    endfunction
    function automatic int sec_v(int p);
        int t [8] = '{16'h0040, 16'h0060, 16'h0060, 16'h0860, 16'h0864, 16'h08E4, 16'h08E5, 16'h08A5};
        return t[p % 8];
    endfunction

    // Expected word for an offset at a position (R1, R3..R7).
    function automatic int exp_word(int off, int p);
        if (off == 0) return 16'h0101;
        if (off == 1) return 16'h3E55;
        if (off == 2) return (sec_v(p) >> 8) & 8'hFF;
        if (off == 3) return sec_v(p) & 8'hFF;
        if (off == TOP - 1) return pri_v(p) & 16'hFF00;
        if (off == TOP) return (pri_v(p) & 8'hFF) << 8;
        return 0;
    endfunction

    function automatic bit is_step(int off);
        return (off == 3) || (off == TOP);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    // One single-cycle read; checks the registered answer (R9).
    task automatic do_read(int off, string req);
        int e;
        @(negedge clk);
        rd_en = 1'b1;
        rd_offset = OW'(off);
        e = exp_word(off, model_pos);
        if (is_step(off)) model_pos = (model_pos + 1) % 8;
        @(negedge clk);
        check(req, int'(rd_data), e);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset data", int'(rd_data), 0);
        rst_n = 1'b1;

        // R2 R3 R4: secondary pair over two full wraps.
        for (int i = 0; i < 16; i++) begin
            do_read(2, "R3 sec upper");
            do_read(3, "R4 sec lower");
        end
        // R5 R6: primary pair over two full wraps.
        for (int i = 0; i < 16; i++) begin
            do_read(TOP - 1, "R5 pri upper");
            do_read(TOP, "R6 pri lower");
        end
        // R2: interleaved order shares one position.
        for (int i = 0; i < 8; i++) begin
            do_read(2, "R2 shared sec upper");
            do_read(TOP - 1, "R2 shared pri upper");
            do_read(3, "R2 shared sec lower");
            do_read(TOP, "R2 shared pri lower");
        end
        // R1: identity words, position unchanged (seen by next upper read).
        do_read(0, "R1 id a");
        do_read(1, "R1 id b");
        do_read(2, "R1 no advance");
        // R7: unmapped offsets read zero and do not move the position.
        do_read(4, "R7 unmapped");
        do_read(5, "R7 unmapped");
        do_read(TOP - 2, "R7 unmapped");
        do_read(16'h1000, "R7 unmapped");
        do_read(TOP - 1, "R7 no advance");
        do_read(3, "R4 lower before hold");

        // R8: hold strobe four cycles on an advancing offset, change offset midway.
        begin
            int e;
            @(negedge clk);
            rd_en = 1'b1;
            rd_offset = OW'(3);
            e = exp_word(3, model_pos);
            model_pos = (model_pos + 1) % 8;
            @(negedge clk);
            check("R8 first cycle data", int'(rd_data), e);
            rd_offset = OW'(0);
            @(negedge clk);
            rd_offset = OW'(TOP);
            @(negedge clk);
            check("R8 held data unchanged", int'(rd_data), e);
            rd_en = 1'b0;
            // R9: idle cycles keep rd_data.
            repeat (3) @(negedge clk);
            check("R9 idle hold", int'(rd_data), e);
        end
        do_read(2, "R8 single advance");
        do_read(TOP - 1, "R8 single advance pri");

        // R10: reset mid-run clears data and position.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset data mid", int'(rd_data), 0);
        rst_n = 1'b1;
        model_pos = 0;
        do_read(3, "R10 position cleared");
        do_read(TOP - 1, "R10 after reset pri");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=0x0000 expected=0x0001");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule